// File: doc/BRIEF.md
# Dual-Modulus Prescaler Control Counter

This block sits after an external prescaler that divides the oscillator by P or P+1. It counts the prescaler's output clock in cycles of N clocks. In dual-modulus operation it drives a modulus-control line. The line is low for the first A clocks of each cycle, which selects P+1. It is high for the remaining N−A clocks, which selects P. The total division from oscillator to cycle is therefore N·P + A. In single-modulus operation the modulus line stays low and the block is a plain divide-by-N.

Each cycle produces two pulses. The divided-output pulse marks the last clock of the cycle. The reload pulse marks the first clock, position one, and tells a neighbouring configuration block when it may move shadowed settings into live registers. Settings are taken from the inputs as they stand.

A select input chooses which edge of the clock switches the modulus line: the rising edge, or the following falling edge for prescalers that sample late. A standby input freezes the counter and forces every output low. A programmed A that is not below N cannot be realised. In that case an error flag rises and the modulus line stays low.

Top module: `modctl_div`

## Requirements
- R1: While reset is asserted, `mod_ctl` and `div_pulse` are 0 and the counter sits at position 1. After release, counting starts from position 1.
- R2: With `dual_en`=0, `div_pulse` is high for exactly one clock in every N clocks, and `mod_ctl` stays 0.
- R3: With `dual_en`=1 and A < N, the cycle positions run 1..N. In rising-edge mode `mod_ctl` is 0 at positions 1..A and 1 at positions A+1..N. When A=0 this makes it 1 for the whole cycle.
- R4: `reload_pulse` is high only at position 1, exactly one clock per cycle, and it follows every `div_pulse` (position N) on the next clock.
- R5: With `edge_fall`=0, `mod_ctl` takes the value for the new position right after the rising edge. With `edge_fall`=1 it changes only at the falling edge that follows, half a clock later.
- R6: While `standby`=1, `mod_ctl`, `div_pulse` and `reload_pulse` are 0 and the counter is held at position 1. On release, the first clock is position 1 with `reload_pulse` high.
- R7: With `dual_en`=1 and A ≥ N, `cfg_err` is 1 and `mod_ctl` stays 0 for the whole cycle. Division by N continues.
- R8: A programmed N below 3 is treated as 3, and one above 16380 is treated as 16380.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | 14 | Cycle length N |
| a_val | input | 7 | Number of P+1 clocks A |
| dual_en | input | 1 | 1 = dual-modulus, 0 = single-modulus |
| edge_fall | input | 1 | 0 = modulus switches on rising edge, 1 = on falling edge |
| standby | input | 1 | Freeze counter, force outputs low |
| mod_ctl | output | 1 | Modulus control (0 selects P+1, 1 selects P) |
| div_pulse | output | 1 | High at the last position of a cycle |
| reload_pulse | output | 1 | High at position 1 of a cycle |
| cfg_err | output | 1 | A not below N in dual mode |

## Verification
The position counter is the only register on the rising-edge path. `div_pulse`, `reload_pulse` and rising-edge `mod_ctl` are therefore due in the same clock as the position they describe, and the bench reads them 2 ns after each rising edge. In falling-edge mode, `mod_ctl` still shows the previous position's value at that point and shows the new one 6 ns after the rising edge, so the bench samples twice per clock there. The bench first synchronises on `reload_pulse` and skips one full cycle after any configuration change, so every expected value is set by position alone.

// File: rtl/modctl_div.sv
module modctl_div #(
  parameter int NW    = 14,
  parameter int AW    = 7,
  parameter int N_MIN = 3,
  parameter int N_MAX = 16380
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_val,
  input  logic [AW-1:0] a_val,
  input  logic          dual_en,
  input  logic          edge_fall,
  input  logic          standby,
  output logic          mod_ctl,
  output logic          div_pulse,
  output logic          reload_pulse,
  output logic          cfg_err
);
  localparam logic [NW-1:0] NLO = NW'(N_MIN);
  localparam logic [NW-1:0] NHI = NW'(N_MAX);
  localparam logic [NW-1:0] ONE = NW'(1);

  logic [NW-1:0] n_eff, a_ext, cnt;
  logic          run, mod_rise, mod_fall;

  assign n_eff = (n_val < NLO) ? NLO : (n_val > NHI) ? NHI : n_val;
  assign a_ext = NW'(a_val);
  assign run   = rst_n && !standby;

  assign cfg_err = dual_en && (a_ext >= n_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= ONE;
    else if (standby)        cnt <= ONE;
    else if (cnt >= n_eff)   cnt <= ONE;
    else                     cnt <= cnt + ONE;
  end

  assign mod_rise = run && dual_en && !cfg_err && (cnt > a_ext);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mod_fall <= 1'b0;
    else        mod_fall <= mod_rise;
  end

  assign mod_ctl      = run && (edge_fall ? mod_fall : mod_rise);
  assign div_pulse    = run && (cnt >= n_eff);
  assign reload_pulse = run && (cnt == ONE);
endmodule

module modctl_div_chk (
  input logic clk,
  input logic rst_n,
  input logic dual_en,
  input logic standby,
  input logic mod_ctl,
  input logic div_pulse,
  input logic reload_pulse,
  input logic cfg_err
);
  // R2: single mode held for two samples keeps the modulus line low
  a_r2_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_en && $past(!dual_en)) |-> !mod_ctl);

  // R4: the clock after the last position is position 1
  a_r4_reload_after_div: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> (reload_pulse || standby));

  // R4: reload never lasts two clocks, since N is at least 3
  a_r4_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reload_pulse);

  // R4: first and last positions never coincide
  a_r4_ends_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(reload_pulse && div_pulse));

  // R6: standby silences every output
  a_r6_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!mod_ctl && !div_pulse && !reload_pulse));

  // R7: an unrealisable configuration keeps the modulus line low
  a_r7_err_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !mod_ctl);
endmodule

bind modctl_div modctl_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .standby(standby),
  .mod_ctl(mod_ctl), .div_pulse(div_pulse),
  .reload_pulse(reload_pulse), .cfg_err(cfg_err)
);

// File: tb/sim_modctl_div.sv
module sim_modctl_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] n_val = 14'd5;
  logic [6:0]  a_val = 7'd0;
  logic        dual_en = 1'b1;
  logic        edge_fall = 1'b0;
  logic        standby = 1'b0;
  logic        mod_ctl, div_pulse, reload_pulse, cfg_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  modctl_div u0 (
    .clk(clk), .rst_n(rst_n), .n_val(n_val), .a_val(a_val),
    .dual_en(dual_en), .edge_fall(edge_fall), .standby(standby),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse),
    .reload_pulse(reload_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic sync_reload(input int n);
    for (int pass = 0; pass < 2; pass++) begin
      step();
      for (int k = 0; k < n + 2 && !reload_pulse; k++) step();
    end
  endtask

  // one full cycle; ep = effective N
  task automatic run_cycle(input string req, input int ep, input int a,
                           input bit dual, input bit fall, input bit err);
    int bad_m, bad_r, bad_d;
    bad_m = 0; bad_r = 0; bad_d = 0;
    sync_reload(ep);
    for (int i = 1; i <= ep; i++) begin
      bit ecur, eprev;
      ecur  = dual && !err && (i > a);
      eprev = dual && !err && (((i == 1) ? ep : i - 1) > a);
      if (reload_pulse !== (i == 1)) bad_r++;
      if (div_pulse !== (i == ep)) bad_d++;
      if (fall) begin
        if (mod_ctl !== eprev) bad_m++;
        #4;
        if (mod_ctl !== ecur) bad_m++;
      end else if (mod_ctl !== ecur) bad_m++;
      if (i < ep) begin
        if (fall) begin @(posedge clk); #2; end
        else step();
      end
    end
    chk({req, " mod pattern mismatches"}, bad_m, 0);
    chk("R4 reload position", bad_r, 0);
    chk({req, " div position"}, bad_d, 0);
  endtask

  task automatic t_reset();
    dual_en = 1'b1; a_val = 7'd0; n_val = 14'd5;
    #3;
    chk("R1 mod during reset", mod_ctl, 0);
    chk("R1 div during reset", div_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 position 1 after release", reload_pulse, 1);
  endtask

  task automatic t_single();
    dual_en = 1'b0; n_val = 14'd5; a_val = 7'd2;
    run_cycle("R2", 5, 2, 1'b0, 1'b0, 1'b0);
    n_val = 14'd7;
    run_cycle("R2", 7, 2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_dual();
    dual_en = 1'b1; edge_fall = 1'b0;
    n_val = 14'd6; a_val = 7'd2;
    run_cycle("R3", 6, 2, 1'b1, 1'b0, 1'b0);
    n_val = 14'd9; a_val = 7'd8;
    run_cycle("R3", 9, 8, 1'b1, 1'b0, 1'b0);
    n_val = 14'd4; a_val = 7'd0;
    run_cycle("R3 a=0", 4, 0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_edge();
    dual_en = 1'b1; edge_fall = 1'b1;
    n_val = 14'd7; a_val = 7'd3;
    run_cycle("R5 falling edge", 7, 3, 1'b1, 1'b1, 1'b0);
    edge_fall = 1'b0;
    run_cycle("R5 rising edge", 7, 3, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_standby();
    int busy;
    busy = 0;
    dual_en = 1'b1; n_val = 14'd6; a_val = 7'd1;
    sync_reload(6);
    step(); step();
    standby = 1'b1;
    #1;
    for (int k = 0; k < 10; k++) begin
      step();
      if (mod_ctl || div_pulse || reload_pulse) busy++;
    end
    chk("R6 outputs quiet in standby", busy, 0);
    #1;
    standby = 1'b0;
    #1;
    chk("R6 release starts at position 1", reload_pulse, 1);
    run_cycle("R6 after release", 6, 1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_err();
    dual_en = 1'b1; n_val = 14'd4; a_val = 7'd4;
    #1;
    chk("R7 error flag a=n", cfg_err, 1);
    run_cycle("R7", 4, 4, 1'b1, 1'b0, 1'b1);
    a_val = 7'd100;
    #1;
    chk("R7 error flag a>n", cfg_err, 1);
    a_val = 7'd3;
    #1;
    chk("R7 no error a<n", cfg_err, 0);
  endtask

  task automatic t_clamp();
    int gap;
    dual_en = 1'b0; a_val = 7'd0;
    n_val = 14'd1;
    run_cycle("R8 low clamp", 3, 0, 1'b0, 1'b0, 1'b0);
    n_val = 14'd16383;
    sync_reload(16383);
    gap = 1;
    while (!div_pulse && gap < 17000) begin step(); gap++; end
    chk("R8 high clamp cycle length", gap, 16380);
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_edge();
    t_standby();
    t_err();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule